// File: doc/BRIEF.md
# Oscillator warm-up one-shot timer

This block times how long a freshly enabled high-speed oscillator is left to settle before the chip starts using it. Software picks which oscillator to count: the on-chip one or the one driven from an external crystal. It then loads a 16-bit cycle count and writes a start command. The counter runs on the chosen oscillator clock. A busy flag, brought back into the register clock domain, tells software when the settling period is over.

A run cannot be cut short. A start command, or a clear of the start bit, written while a run is in progress has no effect. The chosen oscillator and the count value are captured at the moment of the start, so later register writes do not change the run in progress. When the last edge has been counted, the timer clears itself back to idle and accepts a new start.

Two small state machines share the work, one in each clock domain. A request level crosses into the oscillator domain and an acknowledge level crosses back. Each crossing uses a two-flop synchroniser.

Top module: `osc_warmup_timer`

## Requirements
- R1: After reset `busy` is 0, a read of address 0 (control) returns 0 and a read of address 1 (count) returns 0.
- R2: A write to address 1 stores `wr_data[15:0]` as the count value, and a read of address 1 returns it.
- R3: A write to address 0 with bit 0 (start) set, while idle, begins a run. `busy` and read bit 0 of address 0 are 1 from the clock edge that takes the write.
- R4: With count value N, the counter counts N+1 edges of the selected oscillator after it loads. `busy` falls between (N+2) and (N+7) oscillator periods plus 60 ns after the start write.
- R5: Bit 1 of the control write chooses the counted clock: 0 selects `int_osc_clk` and 1 selects `ext_osc_clk`. Read bit 1 of address 0 returns the last value written to bit 1.
- R6: A control write with bit 0 clear while busy does not end the run early.
- R7: A control write with bit 0 set while busy is ignored and does not restart or lengthen the run.
- R8: The clock choice and the count value are captured at the start. Control or count writes during a run change the readable settings but not the run.
- R9: A count value of 0 ends on the first counted edge after the load.
- R10: When a run completes, the timer returns to idle by itself (`busy` 0, read bit 0 of address 0 is 0), and a further start is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register interface clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| int_osc_clk | input | 1 | On-chip high-speed oscillator clock |
| ext_osc_clk | input | 1 | External crystal oscillator clock |
| wr_en | input | 1 | Write strobe, sampled on `clk` |
| reg_addr | input | 1 | 0 = control/status, 1 = count value (used by reads and writes) |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `reg_addr`; control reads {bit1 select, bit0 busy} |
| busy | output | 1 | Run in progress, in the `clk` domain |

## Verification
The bench times each run from the start write to the fall of `busy`. It checks that time against a window worked out from the count value and the period of the chosen oscillator. The two oscillators have periods of 30 ns and 70 ns, so the windows for a 20-count run do not overlap, and a swapped clock selection shows up at once. The same window catches runs that stop early (an honoured clear of the start bit), runs that are lengthened (a restart taken partway through, or a select change that reaches the live counter), and an off-by-count error at N=0 and at N=100.

// File: rtl/owt_pkg.sv
package owt_pkg;
  localparam int CTRL_START_BIT = 0;
  localparam int CTRL_SEL_BIT   = 1;
  localparam logic ADDR_CTRL    = 1'b0;
  localparam logic ADDR_COUNT   = 1'b1;

  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } osc_src_e;

  // Edges counted for a programmed value: the load value itself plus the terminal edge.
  function automatic int unsigned counted_edges(input int unsigned load_val);
    return load_val + 1;
  endfunction
endpackage

// File: rtl/owt_sync.sv
module owt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-2:0], d};
  end

  assign q = shreg[STAGES-1];
endmodule

// File: rtl/owt_reg_if.sv
module owt_reg_if
  import owt_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          reg_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          ack_s,
  output logic          busy,
  output logic          req,
  output osc_src_e      sel_run,
  output logic [CW-1:0] run_count,
  output logic          start_accept,
  output logic [DW-1:0] rd_data
);
  logic          ctrl_wr, count_wr;
  logic          cfg_sel;
  logic [CW-1:0] cfg_count;

  assign ctrl_wr      = wr_en && (reg_addr == ADDR_CTRL);
  assign count_wr     = wr_en && (reg_addr == ADDR_COUNT);
  assign busy         = req | ack_s;
  // A start counts only from idle; a zero in the start bit is never an abort.
  assign start_accept = ctrl_wr && wr_data[CTRL_START_BIT] && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_sel   <= 1'b0;
      cfg_count <= '0;
      req       <= 1'b0;
      sel_run   <= SRC_INT;
      run_count <= '0;
    end else begin
      if (count_wr) cfg_count <= wr_data[CW-1:0];
      if (ctrl_wr)  cfg_sel   <= wr_data[CTRL_SEL_BIT];
      if (start_accept) begin
        req       <= 1'b1;
        sel_run   <= osc_src_e'(wr_data[CTRL_SEL_BIT]);
        run_count <= cfg_count;
      end else if (ack_s) begin
        req <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (reg_addr == ADDR_CTRL) begin
      rd_data[CTRL_START_BIT] = busy;
      rd_data[CTRL_SEL_BIT]   = cfg_sel;
    end else begin
      rd_data[CW-1:0] = cfg_count;
    end
  end
endmodule

// File: rtl/owt_counter.sv
module owt_counter #(
  parameter int CW = 16
) (
  input  logic          cclk,
  input  logic          rst_n,
  input  logic          req_s,
  input  logic [CW-1:0] load_val,
  output logic          act,
  output logic          fin,
  output logic [CW-1:0] cnt,
  output logic          load_evt,
  output logic          done_evt
);
  function automatic logic [CW-1:0] step_down(input logic [CW-1:0] v);
    return v - CW'(1);
  endfunction

  assign load_evt = req_s && !act && !fin;
  assign done_evt = act && (cnt == '0);

  always_ff @(posedge cclk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0;
      fin <= 1'b0;
      cnt <= '0;
    end else if (load_evt) begin
      act <= 1'b1;
      cnt <= load_val;
    end else if (act) begin
      if (done_evt) begin
        act <= 1'b0;
        fin <= req_s;
      end else begin
        cnt <= step_down(cnt);
      end
    end else if (!req_s) begin
      fin <= 1'b0;
    end
  end
endmodule

// File: rtl/osc_warmup_timer.sv
module osc_warmup_timer
  import owt_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          int_osc_clk,
  input  logic          ext_osc_clk,
  input  logic          wr_en,
  input  logic          reg_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          busy
);
  logic          req, req_s, ack, ack_s;
  logic          start_accept, load_evt, done_evt;
  logic          act, fin;
  logic [CW-1:0] cnt, run_count;
  osc_src_e      sel_run;
  logic          cnt_clk;

  // Plain selection: the select only moves while the counter side is idle.
  assign cnt_clk = (sel_run == SRC_EXT) ? ext_osc_clk : int_osc_clk;
  assign ack     = act | fin;

  owt_reg_if #(.DW(DW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .ack_s(ack_s), .busy(busy), .req(req),
    .sel_run(sel_run), .run_count(run_count),
    .start_accept(start_accept), .rd_data(rd_data)
  );

  owt_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(cnt_clk), .rst_n(rst_n), .d(req), .q(req_s)
  );

  owt_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(ack), .q(ack_s)
  );

  owt_counter #(.CW(CW)) u_cnt (
    .cclk(cnt_clk), .rst_n(rst_n), .req_s(req_s), .load_val(run_count),
    .act(act), .fin(fin), .cnt(cnt), .load_evt(load_evt), .done_evt(done_evt)
  );
endmodule

// File: rtl/owt_checker.sv
module owt_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          cnt_clk,
  input logic          rst_n,
  input logic          busy,
  input logic          req,
  input logic          ack_s,
  input logic          start_accept,
  input logic          sel_run,
  input logic [CW-1:0] run_count,
  input logic          act,
  input logic [CW-1:0] cnt,
  input logic          done_evt
);
  a_r3_start_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept |=> busy);

  // R6: the request is only withdrawn once the counter side has answered
  a_r6_req_held_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack_s) |=> req);

  a_r8_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(sel_run));

  a_r8_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(run_count));

  a_r4_count_steps: assert property (@(posedge cnt_clk) disable iff (!rst_n)
    (act && cnt != '0) |=> (act && cnt == $past(cnt) - CW'(1)));

  a_r10_done_to_idle: assert property (@(posedge cnt_clk) disable iff (!rst_n)
    done_evt |=> !act);
endmodule

bind osc_warmup_timer owt_checker #(.CW(CW)) u_chk (
  .clk(clk), .cnt_clk(cnt_clk), .rst_n(rst_n), .busy(busy), .req(req),
  .ack_s(ack_s), .start_accept(start_accept), .sel_run(sel_run),
  .run_count(run_count), .act(act), .cnt(cnt), .done_evt(done_evt)
);

// File: tb/osc_warmup_timer_test.sv
module osc_warmup_timer_test;
  localparam int DW = 16;
  localparam int P_INT = 30;
  localparam int P_EXT = 70;

  logic clk = 1'b0, int_osc_clk = 1'b0, ext_osc_clk = 1'b0;
  logic rst_n = 1'b0, wr_en = 1'b0, reg_addr = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic busy;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;
  always #15 int_osc_clk = ~int_osc_clk;
  initial begin #7; forever #35 ext_osc_clk = ~ext_osc_clk; end

  osc_warmup_timer uut (
    .clk(clk), .rst_n(rst_n), .int_osc_clk(int_osc_clk), .ext_osc_clk(ext_osc_clk),
    .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data), .busy(busy)
  );

  task automatic check(input string tag, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; reg_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [DW-1:0] d);
    @(negedge clk); reg_addr = a; #1 d = rd_data;
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    check("R1 busy after reset", busy == 1'b0, busy, 0);
    rd(1'b0, v); check("R1 control read", v == 0, v, 0);
    rd(1'b1, v); check("R1 count read", v == 0, v, 0);
  endtask

  task automatic t_count_reg;
    logic [DW-1:0] v;
    wr(1'b1, 16'hBEEF); rd(1'b1, v); check("R2 count readback", v == 16'hBEEF, v, 16'hBEEF);
    wr(1'b1, 16'h0123); rd(1'b1, v); check("R2 count readback 2", v == 16'h0123, v, 16'h0123);
  endtask

  // mode: 0 none, 1 clear start mid-run, 2 restart mid-run, 3 flip select mid-run, 4 count write mid-run
  task automatic run_case(input string tag, input bit sel, input int n, input int mode);
    int p = sel ? P_EXT : P_INT;
    longint lo = longint'(n + 2) * p;
    longint hi = longint'(n + 7) * p + 60;
    longint t0, dur;
    logic [DW-1:0] v;
    int k = 0;
    bit hung = 0;
    wr(1'b1, DW'(n));
    @(negedge clk); wr_en = 1'b1; reg_addr = 1'b0; wr_data = {14'b0, sel, 1'b1};
    @(posedge clk); t0 = $time;
    @(negedge clk); wr_en = 1'b0;
    check({tag, " R3 busy after start"}, busy == 1'b1, busy, 1);
    #1 check({tag, " R3 status bit"}, rd_data[0] == 1'b1, rd_data[0], 1);
    check({tag, " R5 select readback"}, rd_data[1] == sel, rd_data[1], sel);
    while (busy) begin
      @(negedge clk); k++;
      if (k == 40 && mode != 0) begin
        wr_en = 1'b1;
        case (mode)
          1: begin reg_addr = 1'b0; wr_data = {14'b0, sel, 1'b0}; end
          2: begin reg_addr = 1'b0; wr_data = {14'b0, sel, 1'b1}; end
          3: begin reg_addr = 1'b0; wr_data = {14'b0, ~sel, 1'b0}; end
          default: begin reg_addr = 1'b1; wr_data = 16'hFFFF; end
        endcase
      end else begin
        wr_en = 1'b0;
      end
      if (k > 20000) begin hung = 1; break; end
    end
    wr_en = 1'b0;
    dur = $time - t0 - 5;
    check({tag, " R4 run did not hang"}, !hung, k, 0);
    check({tag, " R4 duration low bound"}, dur >= lo, dur, lo);
    check({tag, " R4 duration high bound"}, dur <= hi, dur, hi);
    rd(1'b0, v); check({tag, " R10 idle status"}, v[0] == 1'b0, v[0], 0);
    if (mode == 3) check({tag, " R8 select setting updated"}, v[1] == ~sel, v[1], ~sel);
    if (mode == 4) begin
      rd(1'b1, v); check({tag, " R8 count setting updated"}, v == 16'hFFFF, v, 16'hFFFF);
    end
  endtask

  initial begin
    #2_000_000;
    failures++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count_reg();
    run_case("R5 internal n20", 1'b0, 20, 0);
    run_case("R5 external n20", 1'b1, 20, 0);
    run_case("R9 internal n0", 1'b0, 0, 0);
    run_case("R9 external n0", 1'b1, 0, 0);
    run_case("R6 clear start", 1'b0, 20, 1);
    run_case("R7 restart ignored", 1'b0, 20, 2);
    run_case("R8 select flip", 1'b0, 20, 3);
    run_case("R8 count write", 1'b1, 8, 4);
    run_case("R4 internal n100", 1'b0, 100, 0);
    run_case("R10 back to back", 1'b0, 5, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule